// File: doc/BRIEF.md
# Register Initialization Command Sequencer

This block runs a table of initialization records from a start index up to, but not including, an end index, and turns each record into traffic on a simple request/acknowledge register bus. It reads the records from a command memory port. It reads bulk payload words from a separate data memory port. Both ports have a fixed one-cycle read latency. Each record can be one of the following:

- a register read
- a plain write
- an indirect-path write
- a word-string copy, direct or indirect
- a zero fill
- a block copy

Zero fills and block copies go out as length-tagged transfer chunks. Each chunk is at most a parameterized number of words. The sequencer refuses any fill or copy that would not fit the staging buffer.

Software or a boot controller loads the tables, then pulses start with the index range. It waits for the one-cycle done pulse. Error and reject pulses report records that produced no traffic. Payload decompression, the real DMA engine and the indirect mailbox lie outside this block. Their work shows up only as tagged requests on the bus.

Top module: `init_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, reject_o and bus_req_o are all low.
- R2: Record i is stored at command word addresses 2*i (first word) and 2*i+1 (second word). In the first word, bits [7:0] hold the opcode and bits [31:8] hold the 24-bit register offset.
- R3: Opcode 1 issues one request of kind 0 (read) at the offset, with data 0 and length 1; the returned data is discarded. Opcode 2 issues one request of kind 1 (write) whose data is the second word.
- R4: Opcode 3 issues one request of kind 2 (indirect write) whose data is the second word, with length 1.
- R5: For opcodes 4 and 5, the second word holds a payload offset in bits [15:0] and a length in words in bits [31:16]. Word k is read from data address offset+k and written to register offset+4*k. Opcode 4 uses kind 1 and opcode 5 uses kind 2. A zero length issues nothing.
- R6: Opcode 8 splits its length (second word bits [31:16]) into chunks of kind 3. Each chunk is min(remaining, MAX_CHUNK) words long and carries the chunk's payload offset as data. Each chunk advances the register address by 4 times its length.
- R7: Opcode 6 takes the whole second word as its length. It is split into chunks of kind 4 in the same way as R6, with data 0.
- R8: An opcode 6 or 8 record whose length*4 exceeds BUF_BYTES issues no request and pulses reject_o for one cycle.
- R9: Any opcode outside 1 to 6 and 8 (opcode 7 included) issues no request and pulses err_o for one cycle. The sequencer then goes on to the next record.
- R10: A pending request keeps its kind, address, data and length stable until it is acknowledged.
- R11: busy_o is high from the cycle after a start until done_o. done_o pulses for one cycle while busy_o is low, after the last record has finished. If start index equals end index, done_o pulses with no traffic.
- R12: A start pulse while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| start_idx_i | input | IDX_W | First record index |
| end_idx_i | input | IDX_W | Index one past the last record |
| busy_o | output | 1 | Sequencer active |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse per unsupported opcode |
| reject_o | output | 1 | One-cycle pulse per oversized fill or copy |
| cmd_addr_o | output | IDX_W+1 | Command memory word address |
| cmd_rdata_i | input | 32 | Command word, one cycle after its address |
| dat_addr_o | output | 16 | Payload memory word address |
| dat_rdata_i | input | 32 | Payload word, one cycle after its address |
| bus_req_o | output | 1 | Bus request |
| bus_kind_o | output | 3 | 0 read, 1 write, 2 indirect write, 3 block chunk, 4 zero chunk |
| bus_addr_o | output | 24 | Register byte address |
| bus_wdata_o | output | 32 | Write data or chunk payload offset |
| bus_len_o | output | 16 | Words covered by the request |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
Directed tables cover each opcode alone:

- String copies with lengths 0, 2 and 3 separate the per-word address and data stepping from the empty case.
- Block copies of 10, 4 and 16 words with a chunk limit of 4 and a 64-byte buffer separate a remainder chunk, an exact single chunk, and the largest accepted length.
- Lengths of 17 words and a huge fill must be rejected. This pins the comparison edge one word past the buffer size.

Seeded random tables mix all opcodes, including invalid ones, with random acknowledge delays. Start pulses given while busy, and an empty index range, test the start and done handling.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  typedef enum logic [2:0] {
    BK_READ      = 3'd0,
    BK_WRITE     = 3'd1,
    BK_IND_WRITE = 3'd2,
    BK_BLOCK     = 3'd3,
    BK_ZERO      = 3'd4
  } bus_kind_e;

  typedef enum logic [1:0] {
    CL_SINGLE,
    CL_STRING,
    CL_CHUNK,
    CL_SKIP
  } op_class_e;

  localparam logic [7:0] OPC_READ    = 8'd1;
  localparam logic [7:0] OPC_WRITE   = 8'd2;
  localparam logic [7:0] OPC_IWRITE  = 8'd3;
  localparam logic [7:0] OPC_STRING  = 8'd4;
  localparam logic [7:0] OPC_ISTRING = 8'd5;
  localparam logic [7:0] OPC_ZERO    = 8'd6;
  localparam logic [7:0] OPC_BLOCK   = 8'd8;
endpackage

// File: rtl/init_seq_decode.sv
module init_seq_decode
  import init_seq_pkg::*;
#(
  parameter int BUF_BYTES = 4096
) (
  input  logic [7:0]  op_i,
  input  logic [31:0] w1_i,
  output op_class_e   cls_o,
  output bus_kind_e   kind_o,
  output logic [31:0] len_o,
  output logic [15:0] ptr_o,
  output logic        bad_o,
  output logic        reject_o
);
  localparam logic [31:0] BUF_WORDS = 32'(BUF_BYTES / 4);

  op_class_e cls;

  always_comb begin
    cls      = CL_SKIP;
    kind_o   = BK_READ;
    len_o    = '0;
    ptr_o    = '0;
    bad_o    = 1'b0;
    reject_o = 1'b0;
    unique case (op_i)
      OPC_READ:    cls = CL_SINGLE;
      OPC_WRITE:   begin cls = CL_SINGLE; kind_o = BK_WRITE; end
      OPC_IWRITE:  begin cls = CL_SINGLE; kind_o = BK_IND_WRITE; end
      OPC_STRING, OPC_ISTRING: begin
        cls    = CL_STRING;
        kind_o = (op_i == OPC_STRING) ? BK_WRITE : BK_IND_WRITE;
        len_o  = {16'b0, w1_i[31:16]};
        ptr_o  = w1_i[15:0];
      end
      OPC_ZERO: begin
        cls      = CL_CHUNK;
        kind_o   = BK_ZERO;
        len_o    = w1_i;
        reject_o = w1_i > BUF_WORDS;
      end
      OPC_BLOCK: begin
        cls      = CL_CHUNK;
        kind_o   = BK_BLOCK;
        len_o    = {16'b0, w1_i[31:16]};
        ptr_o    = w1_i[15:0];
        reject_o = {16'b0, w1_i[31:16]} > BUF_WORDS;
      end
      default: bad_o = 1'b1;
    endcase
  end

  // empty or refused records produce no traffic
  assign cls_o = (reject_o || (cls != CL_SINGLE && len_o == '0)) ? CL_SKIP : cls;
endmodule

// File: rtl/init_seq_chunk.sv
module init_seq_chunk #(
  parameter int MAX_CHUNK = 256
) (
  input  logic [31:0] rem_i,
  output logic [15:0] chunk_o,
  output logic        last_o
);
  localparam logic [31:0] MAXC = 32'(MAX_CHUNK);

  assign last_o  = rem_i <= MAXC;
  assign chunk_o = last_o ? rem_i[15:0] : MAXC[15:0];
endmodule

// File: rtl/init_seq.sv
module init_seq
  import init_seq_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int MAX_CHUNK = 256,
  parameter int BUF_BYTES = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic [IDX_W-1:0] end_idx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             reject_o,
  output logic [IDX_W:0]   cmd_addr_o,
  input  logic [31:0]      cmd_rdata_i,
  output logic [15:0]      dat_addr_o,
  input  logic [31:0]      dat_rdata_i,
  output logic             bus_req_o,
  output logic [2:0]       bus_kind_o,
  output logic [23:0]      bus_addr_o,
  output logic [31:0]      bus_wdata_o,
  output logic [15:0]      bus_len_o,
  input  logic             bus_ack_i
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RD0, S_RD1, S_DEC, S_DFETCH, S_DLAT, S_BUS
  } state_e;

  state_e          state_q;
  logic [IDX_W-1:0] idx_q, end_q;
  logic [31:0]     w0_q, wdata_q, rem_q;
  logic [23:0]     addr_q;
  logic [15:0]     ptr_q;
  bus_kind_e       kind_q;
  op_class_e       cls_q;
  logic            done_q, err_q, rej_q, next_rec;

  op_class_e   d_cls;
  bus_kind_e   d_kind;
  logic [31:0] d_len;
  logic [15:0] d_ptr, chunk;
  logic        d_bad, d_rej, chunk_last;

  init_seq_decode #(.BUF_BYTES(BUF_BYTES)) u_dec (
    .op_i     (w0_q[7:0]),
    .w1_i     (cmd_rdata_i),
    .cls_o    (d_cls),
    .kind_o   (d_kind),
    .len_o    (d_len),
    .ptr_o    (d_ptr),
    .bad_o    (d_bad),
    .reject_o (d_rej)
  );

  init_seq_chunk #(.MAX_CHUNK(MAX_CHUNK)) u_chunk (
    .rem_i   (rem_q),
    .chunk_o (chunk),
    .last_o  (chunk_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      end_q    <= '0;
      w0_q     <= '0;
      wdata_q  <= '0;
      rem_q    <= '0;
      addr_q   <= '0;
      ptr_q    <= '0;
      kind_q   <= BK_READ;
      cls_q    <= CL_SKIP;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rej_q    <= 1'b0;
      next_rec <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rej_q    <= 1'b0;
      next_rec <= 1'b0;
      if (next_rec) idx_q <= idx_q + 1'b1;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          idx_q   <= start_idx_i;
          end_q   <= end_idx_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (next_rec) begin
            state_q <= S_CHECK;  // wait for the index step to land
          end else if (idx_q >= end_q) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RD0;
          end
        end
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          w0_q    <= cmd_rdata_i;
          state_q <= S_DEC;
        end
        S_DEC: begin
          err_q   <= d_bad;
          rej_q   <= d_rej;
          kind_q  <= d_kind;
          cls_q   <= d_cls;
          addr_q  <= w0_q[31:8];
          rem_q   <= d_len;
          ptr_q   <= d_ptr;
          wdata_q <= (d_kind == BK_READ) ? 32'd0 : cmd_rdata_i;
          unique case (d_cls)
            CL_SINGLE, CL_CHUNK: state_q <= S_BUS;
            CL_STRING:           state_q <= S_DFETCH;
            default: begin
              next_rec <= 1'b1;
              state_q  <= S_CHECK;
            end
          endcase
        end
        S_DFETCH: state_q <= S_DLAT;
        S_DLAT: begin
          wdata_q <= dat_rdata_i;
          state_q <= S_BUS;
        end
        S_BUS: if (bus_ack_i) begin
          unique case (cls_q)
            CL_STRING: begin
              addr_q <= addr_q + 24'd4;
              ptr_q  <= ptr_q + 16'd1;
              rem_q  <= rem_q - 32'd1;
              if (rem_q == 32'd1) begin
                next_rec <= 1'b1;
                state_q  <= S_CHECK;
              end else begin
                state_q <= S_DFETCH;
              end
            end
            CL_CHUNK: begin
              addr_q <= addr_q + {6'b0, chunk, 2'b00};
              ptr_q  <= ptr_q + chunk;
              rem_q  <= rem_q - {16'b0, chunk};
              if (chunk_last) begin
                next_rec <= 1'b1;
                state_q  <= S_CHECK;
              end
            end
            default: begin
              next_rec <= 1'b1;
              state_q  <= S_CHECK;
            end
          endcase
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign reject_o    = rej_q;
  assign cmd_addr_o  = {idx_q, state_q == S_RD1};
  assign dat_addr_o  = ptr_q;
  assign bus_req_o   = state_q == S_BUS;
  assign bus_kind_o  = kind_q;
  assign bus_addr_o  = addr_q;
  assign bus_len_o   = (cls_q == CL_CHUNK) ? chunk : 16'd1;
  assign bus_wdata_o = (cls_q != CL_CHUNK) ? wdata_q :
                       (kind_q == BK_BLOCK) ? {16'b0, ptr_q} : 32'd0;
endmodule

module init_seq_chk #(
  parameter int MAX_CHUNK = 256
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        reject_o,
  input logic        bus_req_o,
  input logic [2:0]  bus_kind_o,
  input logic [23:0] bus_addr_o,
  input logic [31:0] bus_wdata_o,
  input logic [15:0] bus_len_o,
  input logic        bus_ack_i
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_kind_o) && $stable(bus_addr_o)
      && $stable(bus_wdata_o) && $stable(bus_len_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !bus_req_o);
  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || done_o);
  // R9
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !bus_req_o && !reject_o);
  // R8
  rej_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !bus_req_o);
  // R6
  chunk_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_len_o != 16'd0 && 32'(bus_len_o) <= 32'(MAX_CHUNK));
endmodule

bind init_seq init_seq_chk #(.MAX_CHUNK(MAX_CHUNK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .reject_o    (reject_o),
  .bus_req_o   (bus_req_o),
  .bus_kind_o  (bus_kind_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_len_o   (bus_len_o),
  .bus_ack_i   (bus_ack_i)
);

// File: tb/init_seq_bench.sv
`timescale 1ns/1ps
module init_seq_bench;
  localparam int IDX_W = 6;
  localparam int MAXC  = 4;
  localparam int BUFB  = 64;
  localparam int NLOG  = 512;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ack = 1'b0;
  logic [IDX_W-1:0] s_idx = '0, e_idx = '0;
  logic busy, done, err, rej, req;
  logic [IDX_W:0] cmd_addr;
  logic [31:0] cmd_rdata, dat_rdata, wdata;
  logic [15:0] dat_addr, len;
  logic [2:0] kind;
  logic [23:0] addr;

  logic [31:0] cmd_mem [0:127];
  logic [31:0] dat_mem [0:255];

  always #2.5 clk = ~clk;

  init_seq #(.IDX_W(IDX_W), .MAX_CHUNK(MAXC), .BUF_BYTES(BUFB)) u_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_idx_i(s_idx), .end_idx_i(e_idx),
    .busy_o(busy), .done_o(done), .err_o(err), .reject_o(rej),
    .cmd_addr_o(cmd_addr), .cmd_rdata_i(cmd_rdata), .dat_addr_o(dat_addr), .dat_rdata_i(dat_rdata),
    .bus_req_o(req), .bus_kind_o(kind), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_len_o(len), .bus_ack_i(ack));

  always_ff @(posedge clk) begin
    cmd_rdata <= cmd_mem[cmd_addr];
    dat_rdata <= dat_mem[dat_addr[7:0]];
  end

  int checks = 0, fails = 0;
  int n_obs = 0, n_exp = 0, n_done = 0, n_err = 0, n_rej = 0, e_err = 0, e_rej = 0;
  int done_bad = 0;
  logic prev_done = 1'b0;
  logic [2:0]  o_kind [0:NLOG-1], x_kind [0:NLOG-1];
  logic [23:0] o_addr [0:NLOG-1], x_addr [0:NLOG-1];
  logic [31:0] o_data [0:NLOG-1], x_data [0:NLOG-1];
  logic [15:0] o_len  [0:NLOG-1], x_len  [0:NLOG-1];

  task automatic chk(input logic ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // acknowledge with random delay, log accepted requests, count pulses
  initial begin
    forever begin
      @(negedge clk);
      if (req && $urandom_range(0, 2) != 0) begin
        ack = 1'b1;
        if (n_obs < NLOG) begin
          o_kind[n_obs] = kind; o_addr[n_obs] = addr;
          o_data[n_obs] = wdata; o_len[n_obs] = len;
        end
        n_obs++;
      end else begin
        ack = 1'b0;
      end
      if (done) begin
        n_done++;
        if (busy || prev_done) done_bad++;
      end
      prev_done = done;
      if (err) n_err++;
      if (rej) n_rej++;
    end
  end

  task automatic push(input logic [2:0] k, input logic [23:0] a, input logic [31:0] d,
                      input logic [15:0] l);
    if (n_exp < NLOG) begin
      x_kind[n_exp] = k; x_addr[n_exp] = a; x_data[n_exp] = d; x_len[n_exp] = l;
    end
    n_exp++;
  endtask

  task automatic build_exp(input int s, input int e);
    n_exp = 0; e_err = 0; e_rej = 0;
    for (int i = s; i < e; i++) begin
      logic [31:0] w0, w1, ln;
      logic [23:0] a;
      logic [15:0] p, c;
      w0 = cmd_mem[2*i]; w1 = cmd_mem[2*i+1]; a = w0[31:8];
      case (w0[7:0])
        8'd1: push(3'd0, a, 32'd0, 16'd1);
        8'd2: push(3'd1, a, w1, 16'd1);
        8'd3: push(3'd2, a, w1, 16'd1);
        8'd4, 8'd5: begin
          ln = {16'b0, w1[31:16]}; p = w1[15:0];
          for (int k = 0; k < int'(ln); k++)
            push((w0[7:0] == 8'd4) ? 3'd1 : 3'd2, a + 24'(4*k),
                 dat_mem[8'(p + 16'(k))], 16'd1);
        end
        8'd6, 8'd8: begin
          ln = (w0[7:0] == 8'd6) ? w1 : {16'b0, w1[31:16]};
          p = (w0[7:0] == 8'd8) ? w1[15:0] : 16'd0;
          if (64'(ln) * 4 > 64'(BUFB)) e_rej++;
          else while (ln != 0) begin
            c = (ln > MAXC) ? 16'(MAXC) : ln[15:0];
            push((w0[7:0] == 8'd8) ? 3'd3 : 3'd4, a,
                 (w0[7:0] == 8'd8) ? {16'b0, p} : 32'd0, c);
            a = a + {6'b0, c, 2'b00}; p = p + c; ln = ln - {16'b0, c};
          end
        end
        default: e_err++;
      endcase
    end
  endtask

  task automatic run(input int s, input int e, input string rq, input logic extra_start);
    build_exp(s, e);
    n_obs = 0; n_done = 0; n_err = 0; n_rej = 0; done_bad = 0;
    @(negedge clk);
    s_idx = IDX_W'(s); e_idx = IDX_W'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R11", "busy after start", busy, 1);
    if (extra_start) begin
      repeat (3) @(negedge clk);
      chk(busy === 1'b1, "R12", "busy at second start", busy, 1);
      s_idx = 0; e_idx = 3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done > 0);
    repeat (12) @(negedge clk);
    chk(n_obs == n_exp, rq, "request count", n_obs, n_exp);
    for (int i = 0; i < n_exp && i < n_obs && i < NLOG; i++) begin
      chk(o_kind[i] == x_kind[i] && o_addr[i] == x_addr[i] &&
          (x_kind[i] == 3'd0 || o_data[i] == x_data[i]) && o_len[i] == x_len[i],
          rq, $sformatf("req %0d kind/addr/data/len", i),
          {o_kind[i], o_addr[i], o_data[i][15:0], o_len[i]},
          {x_kind[i], x_addr[i], x_data[i][15:0], x_len[i]});
    end
    chk(n_err == e_err, "R9", "err pulses", n_err, e_err);
    chk(n_rej == e_rej, "R8", "reject pulses", n_rej, e_rej);
    chk(n_done == 1 && done_bad == 0, "R11", "single done pulse while idle", n_done, 1);
  endtask

  task automatic rec(input int i, input logic [7:0] op, input logic [23:0] off,
                     input logic [31:0] w1);
    cmd_mem[2*i] = {off, op}; cmd_mem[2*i+1] = w1;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 128; i++) cmd_mem[i] = 32'd0;
    for (int i = 0; i < 256; i++) dat_mem[i] = $urandom;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !err && !rej && !req, "R1", "outputs in reset",
        {busy, done, err, rej, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req, "R1", "idle after reset", {busy, req}, 0);

    // R2 R3
    rec(5, 8'd1, 24'h123456, 32'hffff_ffff);
    rec(6, 8'd2, 24'h000010, 32'hdead_beef);
    run(5, 7, "R3", 1'b0);
    // R4
    rec(0, 8'd3, 24'hab_cdef, 32'h0bad_f00d);
    rec(1, 8'd2, 24'h000020, 32'h1111_2222);
    run(0, 2, "R4", 1'b0);
    // R5 lengths 3, 2, 0
    rec(0, 8'd4, 24'h001000, {16'd3, 16'd10});
    rec(1, 8'd5, 24'h002000, {16'd2, 16'd20});
    rec(2, 8'd4, 24'h003000, {16'd0, 16'd30});
    run(0, 3, "R5", 1'b0);
    // R6 remainder, exact, max accepted
    rec(0, 8'd8, 24'h004000, {16'd10, 16'd40});
    rec(1, 8'd8, 24'h005000, {16'd4, 16'd50});
    rec(2, 8'd8, 24'h006000, {16'd16, 16'd60});
    run(0, 3, "R6", 1'b0);
    // R7
    rec(0, 8'd6, 24'h007000, 32'd7);
    rec(1, 8'd6, 24'h008000, 32'd1);
    run(0, 2, "R7", 1'b0);
    // R8 one past limit and huge
    rec(0, 8'd8, 24'h009000, {16'd17, 16'd0});
    rec(1, 8'd6, 24'h00a000, 32'd17);
    rec(2, 8'd6, 24'h00b000, 32'h1000_0000);
    rec(3, 8'd2, 24'h00c000, 32'h5);
    run(0, 4, "R8", 1'b0);
    // R9
    rec(0, 8'd7, 24'h00d000, 32'h0);
    rec(1, 8'd0, 24'h00d100, 32'h0);
    rec(2, 8'd9, 24'h00d200, 32'h0);
    rec(3, 8'hff, 24'h00d300, 32'h0);
    rec(4, 8'd2, 24'h00d400, 32'h77);
    run(0, 5, "R9", 1'b0);
    // R11 empty range
    run(4, 4, "R11", 1'b0);
    // R12 start while busy
    rec(10, 8'd4, 24'h00e000, {16'd4, 16'd100});
    rec(11, 8'd6, 24'h00f000, 32'd9);
    run(10, 12, "R12", 1'b1);
    // random tables, R2 record addressing
    for (int t = 0; t < 20; t++) begin
      int b;
      b = $urandom_range(0, 40);
      for (int i = b; i < b + 8; i++) begin
        logic [7:0] op;
        logic [23:0] off;
        op = 8'($urandom_range(0, 9));
        off = 24'($urandom);
        case (op)
          8'd4, 8'd5: rec(i, op, off, {16'($urandom_range(0, 5)), 16'($urandom_range(0, 200))});
          8'd6:       rec(i, op, off, 32'($urandom_range(0, 20)));
          8'd8:       rec(i, op, off, {16'($urandom_range(0, 20)), 16'($urandom_range(0, 200))});
          default:    rec(i, op, off, $urandom);
        endcase
      end
      run(b, b + 8, "R2", 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule